// File: doc/BRIEF.md
# Four-Phase Traffic Light Sequencer

This block steps a single traffic signal through a fixed loop of four phases: green, then yellow, then red, then red with yellow, and back to green. It is a Moore machine. The three lamp enables depend only on the current phase, so they never respond to an input within the same cycle.

Time is measured in ticks. The `tick_i` input marks the cycles that count, and the block remains in each phase for `DWELL` counted ticks. Cycles with `tick_i` low pause the machine. The phase does not change and the tick count is kept, which lets a slow timebase pace the light from a fast clock.

A parameter chooses how the phase is stored. The binary option uses 2 bits. The one-hot option uses 4 bits. The output-coded option uses 3 bits, and those bits are the lamp enables themselves. The outputs are the same under every option.

Top module: `tl_sequencer`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it goes high, only `green_o` is lit, and the tick count is cleared. Asserting reset takes effect at once, without waiting for a clock edge.
- R2: The phases are always visited in the same order. The lamp pattern as {red_o,yellow_o,green_o} goes 001 (green), 010 (yellow), 100 (red), 110 (red+yellow), then back to 001.
- R3: The phase advances on the rising clock edge at which `tick_i` is high for the `DWELL`-th time since the phase was entered. The new lamp pattern is visible straight after that edge.
- R4: A clock edge with `tick_i` low changes neither the phase nor the stored tick count.
- R5: When `tick_i` is held high, every phase lasts exactly `DWELL` clock cycles.
- R6: At every cycle the lamp pattern is one of 001, 010, 100 or 110.
- R7: With `ENC` set to binary, one-hot or output-coded, the block gives identical lamp outputs cycle for cycle under the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Marks the cycles that count toward the dwell time |
| red_o | output | 1 | Red lamp enable |
| yellow_o | output | 1 | Yellow lamp enable |
| green_o | output | 1 | Green lamp enable |

## Verification
A run with `tick_i` held high gives the cleanest view of phase order and dwell length, since each phase should then last exactly `DWELL` cycles. A long stretch with `tick_i` low, placed partway through a phase, shows whether paused cycles are wrongly counted: the phase that follows must still need the remaining ticks. Random tick streams of about 75% density place the terminal tick at every offset, and a reset asserted partway through the run checks the asynchronous return to green. All three encodings are driven from the same stimulus and compared against one reference model, so any difference between them shows up as a mismatch.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [1:0] {
    ENC_BINARY = 2'd0,
    ENC_ONEHOT = 2'd1,
    ENC_OUTPUT = 2'd2
  } enc_e;

  typedef struct packed {
    logic red;
    logic yellow;
    logic green;
  } lamp_t;

  localparam lamp_t LAMP_G  = 3'b001;
  localparam lamp_t LAMP_Y  = 3'b010;
  localparam lamp_t LAMP_R  = 3'b100;
  localparam lamp_t LAMP_RY = 3'b110;

  function automatic logic lamp_legal(lamp_t l);
    return (l == LAMP_G) || (l == LAMP_Y) || (l == LAMP_R) || (l == LAMP_RY);
  endfunction

endpackage

// File: rtl/tl_dwell_cnt.sv
module tl_dwell_cnt #(
  parameter int unsigned DWELL = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic adv_o
);
  localparam int unsigned CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

  logic [CNT_W-1:0] cnt_q;

  assign adv_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (adv_o)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/tl_phase_core.sv
module tl_phase_core
  import tl_pkg::*;
#(
  parameter enc_e ENC = ENC_BINARY
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  output lamp_t lamp_o
);

  generate
    if (ENC == ENC_ONEHOT) begin : g_onehot
      // bit0 green, bit1 yellow, bit2 red, bit3 red+yellow
      logic [3:0] st_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     st_q <= 4'b0001;
        else if (adv_i)  st_q <= {st_q[2:0], st_q[3]};
      end
      assign lamp_o.green  = st_q[0];
      assign lamp_o.yellow = st_q[1] | st_q[3];
      assign lamp_o.red    = st_q[2] | st_q[3];

      assert_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(st_q) == 1);
    end else if (ENC == ENC_OUTPUT) begin : g_outcode
      // state bits are the lamp enables
      lamp_t st_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= LAMP_G;
        else if (adv_i) begin
          unique case (st_q)
            LAMP_G:  st_q <= LAMP_Y;
            LAMP_Y:  st_q <= LAMP_R;
            LAMP_R:  st_q <= LAMP_RY;
            default: st_q <= LAMP_G;
          endcase
        end
      end
      assign lamp_o = st_q;
    end else begin : g_binary
      logic [1:0] st_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     st_q <= 2'd0;
        else if (adv_i)  st_q <= st_q + 2'd1;
      end
      always_comb begin
        unique case (st_q)
          2'd0:    lamp_o = LAMP_G;
          2'd1:    lamp_o = LAMP_Y;
          2'd2:    lamp_o = LAMP_R;
          default: lamp_o = LAMP_RY;
        endcase
      end
    end
  endgenerate

  assert_green_to_yellow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && lamp_o == LAMP_G) |=> lamp_o == LAMP_Y);

  assert_ry_to_green_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && lamp_o == LAMP_RY) |=> lamp_o == LAMP_G);

  assert_phase_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(lamp_o));

endmodule

// File: rtl/tl_sequencer.sv
module tl_sequencer
  import tl_pkg::*;
#(
  parameter int unsigned DWELL = 4,
  parameter enc_e        ENC   = ENC_BINARY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic red_o,
  output logic yellow_o,
  output logic green_o
);
  logic  adv;
  lamp_t lamp;

  tl_dwell_cnt #(.DWELL(DWELL)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .adv_o  (adv)
  );

  tl_phase_core #(.ENC(ENC)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .lamp_o (lamp)
  );

  assign red_o    = lamp.red;
  assign yellow_o = lamp.yellow;
  assign green_o  = lamp.green;

  assert_lamp_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lamp_legal({red_o, yellow_o, green_o}));

  assert_adv_needs_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable({red_o, yellow_o, green_o}));

endmodule

// File: tb/tb_tl_sequencer.sv
module tb_tl_sequencer;
  import tl_pkg::*;

  localparam int unsigned D = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic r0, y0, g0, r1, y1, g1, r2, y2, g2;

  int n_vec = 0;
  int n_bad = 0;
  int ph = 0;
  int cnt = 0;

  always #10 clk = ~clk;

  tl_sequencer #(.DWELL(D), .ENC(ENC_BINARY)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .red_o(r0), .yellow_o(y0), .green_o(g0));
  tl_sequencer #(.DWELL(D), .ENC(ENC_ONEHOT)) dut_oh (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .red_o(r1), .yellow_o(y1), .green_o(g1));
  tl_sequencer #(.DWELL(D), .ENC(ENC_OUTPUT)) dut_oc (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .red_o(r2), .yellow_o(y2), .green_o(g2));

  function automatic logic [2:0] exp_lamp(int p);
    case (p)
      0:       return 3'b001;
      1:       return 3'b010;
      2:       return 3'b100;
      default: return 3'b110;
    endcase
  endfunction

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: lamps got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, {r0, y0, g0}, exp_lamp(ph));
    chk("R7 onehot", {r1, y1, g1}, exp_lamp(ph));
    chk("R7 outcode", {r2, y2, g2}, exp_lamp(ph));
  endtask

  // drive at negedge, model the edge, check at next negedge
  task automatic step(logic t, string req);
    tick = t;
    @(posedge clk);
    if (t) begin
      if (cnt == D - 1) begin cnt = 0; ph = (ph + 1) % 4; end
      else cnt++;
    end
    @(negedge clk);
    chk_all(req);
  endtask

  initial begin
    int seed_set;
    logic [2:0] prev;
    int len;
    seed_set = $urandom(32'h5EED_0042);

    // R1: lamps during reset
    repeat (2) @(negedge clk);
    chk_all("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_all("R1 after release");

    // R2/R5: ticks held high, measure each phase length
    prev = {r0, y0, g0};
    len = 0;
    for (int i = 0; i < 4 * D * 3; i++) begin
      step(1'b1, "R2");
      len++;
      if ({r0, y0, g0} != prev) begin
        n_vec++;
        if (len != D) begin
          n_bad++;
          $display("FAIL R5: phase length got %0d expected %0d", len, D);
        end
        len = 0;
        prev = {r0, y0, g0};
      end
    end

    // R4: one tick into a phase, then a long pause
    step(1'b1, "R3");
    for (int i = 0; i < 25; i++) step(1'b0, "R4 pause");
    for (int i = 0; i < D - 1; i++) step(1'b1, "R3 resume");

    // R3: ticks on alternate cycles
    for (int i = 0; i < 40; i++) step(i[0], "R3 alternate");

    // random tick density about 75%
    for (int i = 0; i < 500; i++) step(($urandom % 4) != 0, "R3 random");

    // R1: asynchronous reset partway through a phase
    step(1'b1, "R3");
    #3 rst_ni = 1'b0;
    #2;
    ph = 0; cnt = 0;
    chk_all("R1 async");
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < D - 1; i++) step(1'b1, "R1 count cleared");
    chk_all("R1 still green");
    step(1'b1, "R1 first advance");

    for (int i = 0; i < 300; i++) step(($urandom % 4) != 0, "R6 random");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule